// File: doc/BRIEF.md
# Pre-Trigger Ring Capture Engine

This block records a fast digital signal into on-chip memory, as the acquisition core of a logic analyser or oscilloscope does. Software raises an arm control bit. From the next cycle on, the block writes one sample per clock into a ring buffer whose write pointer wraps at the end of the memory. While this goes on, it watches one bit of the sample for a selectable edge. After a qualified trigger, the block writes a programmed number of further samples and then stops. The samples that came before the trigger therefore stay in the buffer.

A second memory port is fully independent of the capture side and gives a processor-bus interface a synchronous read. Two status outputs report the controller state and the address of the last sample written. With that address, software can rotate the ring contents into time order: the oldest sample sits at the address after it. To rearm, software first clears the arm bit, which returns the block to idle, and then sets it again.

Top module: `trig_ring_capture`

## Requirements
- R1: With `state_o` at IDLE (encoding 0) and `arm` high at a clock edge, `state_o` becomes ARMED (1) after that edge, and the first sample of the capture is written to address 0.
- R2: If `arm` is low at a clock edge while `state_o` is ARMED, POST (2) or DONE (3), `state_o` becomes IDLE after that edge.
- R3: In every cycle with `state_o` ARMED or POST and `arm` high, `sample_in` is written at the write pointer, and the pointer then advances by one modulo DEPTH.
- R4: A trigger edge occurs when bit TRIG_BIT of `sample_in` differs from its value in the previous cycle. With `edge_fall`=0 only a 0-to-1 change counts; with `edge_fall`=1 only a 1-to-0 change counts.
- R5: In ARMED, an edge is ignored, and the state stays ARMED, unless at least DEPTH-1-P samples were written in earlier cycles of this capture, where P is the effective post count.
- R6: An accepted edge with P>0 moves the state to POST. After P further samples have been written, the state is DONE, and no write takes place in DONE.
- R7: With P=0, an accepted edge moves the state straight from ARMED to DONE, and the sample carrying the edge is the last one written.
- R8: P is taken from `post_count` at the cycle that leaves IDLE. Any value of DEPTH or more is clamped to DEPTH-1.
- R9: In DONE, `stop_addr` shows the address of the last sample written and holds it until the next capture ends.
- R10: When `rd_en` is high at an edge, `rd_data` shows the word at `rd_addr` one cycle later. When `rd_en` is low, `rd_data` holds its value.
- R11: After reset, `state_o` is IDLE, `stop_addr` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arm | input | 1 | Control bit: high arms and holds a capture, low returns to idle |
| edge_fall | input | 1 | Trigger polarity: 0 rising, 1 falling |
| post_count | input | CW | Number of samples to write after the trigger |
| sample_in | input | SW | Sample written each capture cycle |
| rd_en | input | 1 | Read strobe of the bus port |
| rd_addr | input | AW | Read address of the bus port |
| rd_data | output | SW | Registered read word |
| state_o | output | 2 | Controller state: 0 IDLE, 1 ARMED, 2 POST, 3 DONE |
| stop_addr | output | AW | Address of the last sample written |

## Verification
Every state change, pointer step and `stop_addr` update is due one clock after the edge whose inputs caused it. A bus read is due one clock after its strobe. The reference model in the bench advances once per clock from the same held inputs. The bench drives inputs on the falling edge and compares on the next falling edge, so each result is checked in the cycle it is due. The ring contents are read out only in DONE, when no writes happen, so read data cannot race the capture port.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2,
    ST_DONE  = 2'd3
  } trc_state_e;
endpackage

// File: rtl/trc_rst_sync.sv
module trc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/trc_edge.sv
module trc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic probe,
  input  logic fall_sel,
  output logic hit
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = prev_q;
    if (en) prev_d = probe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  always_comb begin
    if (fall_sel) hit = prev_q & ~probe;
    else          hit = ~prev_q & probe;
  end
endmodule

// File: rtl/trc_ram.sv
module trc_ram #(
  parameter int SW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [SW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [SW-1:0] rd_data
);
  logic [SW-1:0] mem [DEPTH];
  logic [SW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          hit,
  input  logic [CW-1:0] post_count,
  output logic [1:0]    state_o,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] stop_addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL = (AW+1)'(DEPTH);

  trc_state_e    state_q, state_d;
  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW:0]   fill_q, fill_d;
  logic [AW-1:0] rem_q, rem_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [AW-1:0] stop_q, stop_d;

  logic [31:0]   pc_wide;
  logic [AW-1:0] pc_clamp;
  logic [AW-1:0] pre_need;
  logic          qualified;
  logic          capturing;

  always_comb begin
    pc_wide  = 32'(post_count);
    pc_clamp = (pc_wide >= 32'(DEPTH)) ? LAST : pc_wide[AW-1:0];
    pre_need = LAST - pc_q;
    qualified = (fill_q >= {1'b0, pre_need});
    capturing = arm && ((state_q == ST_ARMED) || (state_q == ST_POST));
  end

  always_comb begin
    state_d = state_q;
    wptr_d  = wptr_q;
    fill_d  = fill_q;
    rem_d   = rem_q;
    pc_d    = pc_q;
    stop_d  = stop_q;
    if (capturing) begin
      wptr_d = wptr_q + 1'b1;
      if (fill_q != FULL) fill_d = fill_q + 1'b1;
    end
    unique case (state_q)
      ST_IDLE: begin
        if (arm) begin
          state_d = ST_ARMED;
          wptr_d  = '0;
          fill_d  = '0;
          pc_d    = pc_clamp;
        end
      end
      ST_ARMED: begin
        if (!arm) begin
          state_d = ST_IDLE;
        end else if (hit && qualified) begin
          if (pc_q == '0) begin
            state_d = ST_DONE;
            stop_d  = wptr_q;
          end else begin
            state_d = ST_POST;
            rem_d   = pc_q;
          end
        end
      end
      ST_POST: begin
        if (!arm) begin
          state_d = ST_IDLE;
        end else begin
          rem_d = rem_q - 1'b1;
          if (rem_q == AW'(1)) begin
            state_d = ST_DONE;
            stop_d  = wptr_q;
          end
        end
      end
      ST_DONE: begin
        if (!arm) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wptr_q  <= '0;
      fill_q  <= '0;
      rem_q   <= '0;
      pc_q    <= '0;
      stop_q  <= '0;
    end else begin
      state_q <= state_d;
      wptr_q  <= wptr_d;
      fill_q  <= fill_d;
      rem_q   <= rem_d;
      pc_q    <= pc_d;
      stop_q  <= stop_d;
    end
  end

  assign state_o   = state_q;
  assign wr_en     = capturing;
  assign wr_addr   = wptr_q;
  assign stop_addr = stop_q;
endmodule

// File: rtl/trig_ring_capture.sv
module trig_ring_capture #(
  parameter int SW       = 8,
  parameter int DEPTH    = 64,
  parameter int CW       = 8,
  parameter int TRIG_BIT = 0,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          edge_fall,
  input  logic [CW-1:0] post_count,
  input  logic [SW-1:0] sample_in,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [SW-1:0] rd_data,
  output logic [1:0]    state_o,
  output logic [AW-1:0] stop_addr
);
  logic          rst_int_n;
  logic          hit;
  logic          wr_en;
  logic [AW-1:0] wr_addr;

  trc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  trc_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (1'b1),
    .probe    (sample_in[TRIG_BIT]),
    .fall_sel (edge_fall),
    .hit      (hit)
  );

  trc_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .arm        (arm),
    .hit        (hit),
    .post_count (post_count),
    .state_o    (state_o),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .stop_addr  (stop_addr)
  );

  trc_ram #(.SW(SW), .DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (sample_in),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic [1:0]    state,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] stop_addr
);
  p_arm_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && arm) |=> (state == 2'd1 && wr_addr == '0));

  p_disarm_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'd0 && !arm) |=> (state == 2'd0));

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == AW'($past(wr_addr) + 1'b1)));

  p_write_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (state == 2'd1 || state == 2'd2));

  p_stop_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3 && $past(state) != 2'd3) |-> (stop_addr == $past(wr_addr)));

  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3 && $past(state) == 2'd3) |-> $stable(stop_addr));
endmodule

bind trig_ring_capture trc_checker #(.AW(AW)) u_trc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm       (arm),
  .state     (state_o),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .stop_addr (stop_addr)
);

// File: tb/test_trig_ring_capture.sv
module test_trig_ring_capture;
  localparam int SW = 8;
  localparam int DEPTH = 16;
  localparam int CW = 6;
  localparam int TB_TRIG = 7;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic edge_fall = 1'b0;
  logic [CW-1:0] post_count = '0;
  logic [SW-1:0] sample_in = '0;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [SW-1:0] rd_data;
  logic [1:0] state_o;
  logic [AW-1:0] stop_addr;

  always #10 clk = ~clk;

  trig_ring_capture #(.SW(SW), .DEPTH(DEPTH), .CW(CW), .TRIG_BIT(TB_TRIG)) i_trig_ring_capture (
    .clk(clk), .rst_n(rst_n), .arm(arm), .edge_fall(edge_fall),
    .post_count(post_count), .sample_in(sample_in), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .state_o(state_o), .stop_addr(stop_addr)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // behavioural reference model
  int m_state = 0, m_wptr = 0, m_fill = 0, m_rem = 0, m_pc = 0, m_stop = 0, m_rd = 0;
  bit m_prev = 0;
  int m_mem [DEPTH];
  int lo = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_tick();
    bit b, hit, cap;
    int nst;
    b = sample_in[TB_TRIG];
    hit = edge_fall ? (m_prev && !b) : (!m_prev && b);
    if (rd_en) m_rd = m_mem[rd_addr];
    nst = m_state;
    cap = arm && (m_state == 1 || m_state == 2);
    if (m_state == 0) begin
      if (arm) begin
        nst = 1; m_wptr = 0; m_fill = 0;
        m_pc = (post_count >= DEPTH) ? DEPTH - 1 : int'(post_count);
      end
    end else if (!arm) begin
      nst = 0;
    end else if (m_state == 1) begin
      if (hit && m_fill >= DEPTH - 1 - m_pc) begin
        if (m_pc == 0) begin nst = 3; m_stop = m_wptr; end
        else begin nst = 2; m_rem = m_pc; end
      end
    end else if (m_state == 2) begin
      m_rem--;
      if (m_rem == 0) begin nst = 3; m_stop = m_wptr; end
    end
    if (cap) begin
      m_mem[m_wptr] = int'(sample_in);
      m_wptr = (m_wptr + 1) % DEPTH;
      if (m_fill < DEPTH) m_fill++;
    end
    m_prev = b;
    m_state = nst;
  endtask

  task automatic step(input string tag);
    model_tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    chk(tag, int'(state_o), m_state);
    if (m_state == 3) chk({tag, " stop_addr R9"}, int'(stop_addr), m_stop);
  endtask

  task automatic feed(input int n, input bit tb, input string tag);
    for (int i = 0; i < n; i++) begin
      lo = (lo + 1) % 128;
      sample_in = {tb, 7'(lo)};
      step(tag);
    end
  endtask

  task automatic run_to_done(input bit tb, input string tag);
    for (int i = 0; i < 4 * DEPTH && m_state != 3; i++) feed(1, tb, tag);
    chk({tag, " reached DONE"}, int'(state_o), 3);
  endtask

  task automatic readout(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      rd_en = 1'b1;
      rd_addr = AW'(a);
      step(tag);
      chk({tag, " rd_data"}, int'(rd_data), m_rd);
    end
    rd_en = 1'b0;
    rd_addr = '0;
    step("R10 hold");
    chk("R10 rd_data held with rd_en low", int'(rd_data), m_rd);
    arm = 1'b0;
    step("R2 disarm from DONE");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 reset state", int'(state_o), 0);
    chk("R11 reset stop_addr", int'(stop_addr), 0);
    chk("R11 reset rd_data", int'(rd_data), 0);

    // rising trigger, P=4, early edge ignored
    edge_fall = 1'b0; post_count = 6'd4; arm = 1'b1;
    feed(1, 0, "R1 arm");
    feed(2, 0, "R3 fill");
    feed(2, 1, "R5 early rise ignored");
    feed(10, 0, "R3 fill");
    feed(1, 1, "R4 rising accepted");
    chk("R6 POST after trigger", int'(state_o), 2);
    run_to_done(1, "R6 post count");
    readout("R3 ring content");

    // falling trigger, P=0
    edge_fall = 1'b1; post_count = 6'd0; arm = 1'b1;
    feed(5, 1, "R1 arm");
    feed(3, 0, "R5 early fall ignored");
    feed(8, 1, "R4 rising ignored when falling selected");
    feed(1, 0, "R7 zero post count");
    chk("R7 DONE straight from trigger", int'(state_o), 3);
    readout("R7 ring content");

    // oversized post count clamped
    edge_fall = 1'b0; post_count = 6'd40; arm = 1'b1;
    feed(1, 0, "R1 arm");
    post_count = 6'd0;
    feed(1, 1, "R8 clamp edge");
    run_to_done(1, "R8 clamped post count");
    readout("R1 first sample at address 0");

    // abort while armed
    arm = 1'b1;
    feed(3, 0, "R1 arm");
    arm = 1'b0;
    feed(1, 0, "R2 abort from ARMED");
    feed(2, 0, "R2 idle");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule